// File: doc/BRIEF.md
# Cascadable Dual-Port RAM Tile

A synchronous RAM tile with two fully independent ports, A and B. Both ports reach one shared store of 4096 rows, each 72 bits wide. The word width of both ports is fixed at build time to 72, 36, 18 or 9 bits. At narrower widths a row holds two, four or eight words, so the depth grows as the width shrinks and the total storage stays the same. Each port presents a 26-bit address. The low fifteen bits locate a word inside the tile. The upper eleven bits locate a tile inside a deep array made of several tiles.

Each tile carries an eleven-bit identity and an eleven-bit compare mask. When chaining is enabled, a port access belongs to this tile only if the masked upper address bits equal the masked identity. A tile that is not addressed writes nothing and returns zero, so the read buses of many tiles can simply be ORed together. Writes are gated per lane by byte enables. At 72 bits the enables come in two groupings: one treats every 9-bit group alike, the other separates eight data bytes from a parity byte.

Top module: `ram_tile`

## Requirements
- R1: With port width W, the row is addr[14:3] and the slice is addr[2:0] shifted right by S, where S is 3, 2, 1 or 0 for W = 72, 36, 18 or 9. The slice occupies bits [W*slice +: W] of the row, which gives 4096*72/W independent words.
- R2: Address bits below bit S have no effect on which word is read or written.
- R3: With chaining on, a port is selected exactly when ((addr[25:15] XOR SELF_ID) AND SELF_MASK) is zero. A mask bit of 1 takes part in the compare, and a mask bit of 0 always matches.
- R4: With chaining off, every access is selected whatever the value of addr[25:15].
- R5: Except at 72 bits with split parity, enable bit k gates data bits [9k+8:9k]. The enable width is W/9.
- R6: At 72 bits with split parity (9 enables), enable k for k < 8 gates data bits [8k+7:8k], and enable 8 gates bits [71:64].
- R7: An access that is not selected changes no stored bit, and that port's read output is zero in the following cycle.
- R8: Read data appears one cycle after the address. A read of a word being written in the same cycle, by either port, returns the data held before that write.
- R9: When both ports write the same word in one cycle, port B's enabled groups take precedence. Groups enabled only on port A keep A's data.
- R10: After any clock edge at which rst_n is low, both read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_addr | input | 26 | Port A address: tile select [25:15], word select [14:0] |
| a_din | input | WIDTH | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_bwe | input | BWE_W | Port A lane write enables |
| a_dout | output | WIDTH | Port A read data, one cycle latency |
| b_addr | input | 26 | Port B address |
| b_din | input | WIDTH | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_bwe | input | BWE_W | Port B lane write enables |
| b_dout | output | WIDTH | Port B read data, one cycle latency |

## Verification
The functions that collide are a write on one port and a read or write of the same word on the other port in the same cycle. The bench provokes this with directed cycles in which port A writes a word while port B reads it, and in which both ports write one word with overlapping and with disjoint lane enables. Random traffic confined to a few rows adds further collisions. A behavioural model holds the old contents for same-cycle reads and applies A's write before B's. Every output is compared on every clock, and bits never written are left out of the comparison.

// File: rtl/ram_tile_pkg.sv
// Shared constants and elaboration-time helpers for the RAM tile.
// Assumes: row width is fixed at 72 bits, port widths are 72, 36, 18 or 9.
package ram_tile_pkg;

    localparam int ADDR_W = 26;
    localparam int UP_W   = 11;
    localparam int LOW_W  = 15;
    localparam int SUB_W  = 3;
    localparam int ROW_W  = 72;
    localparam int ROW_AW = LOW_W - SUB_W;
    localparam int ROWS   = 1 << ROW_AW;
    localparam int OFF_W  = 7;

    // Number of low address bits that a given port width leaves unused.
    function automatic int sub_shift(input int w);
        if (w == 72) return 3;
        if (w == 36) return 2;
        if (w == 18) return 1;
        return 0;
    endfunction

    // Width of the lane enable bus for a given port width and parity mode.
    function automatic int bwe_width(input int w, input bit split_par);
        if (w == 72) return split_par ? 9 : 8;
        return w / 9;
    endfunction

    // Which enable bit gates data bit 'pos'.
    function automatic int bwe_group(input int w, input bit split_par, input int pos);
        if (w == 72 && split_par) return (pos < 64) ? pos / 8 : 8;
        return pos / 9;
    endfunction

endpackage

// File: rtl/ram_tile_select.sv
// Tile self-select comparator.
// Decides whether an access's upper address bits point at this tile.
// Assumes: a mask bit of 1 takes part in the compare.
module ram_tile_select
    import ram_tile_pkg::*;
#(
    parameter bit              CASCADE_EN = 1'b0,
    parameter logic [UP_W-1:0] SELF_ID    = '0,
    parameter logic [UP_W-1:0] SELF_MASK  = '1
) (
    input  logic [UP_W-1:0] upper,
    output logic            hit
);

    generate
        if (CASCADE_EN) begin : g_chain
            // Compare only the unmasked upper bits against the identity.
            always_comb hit = (((upper ^ SELF_ID) & SELF_MASK) == '0);
        end else begin : g_single
            // A lone tile owns every access.
            always_comb hit = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/ram_tile_lane.sv
// Per-port width adapter.
// Maps a port word onto the 72-bit row: row index, shifted write data and
// per-bit write mask. Picks the port word back out of the registered row.
// Assumes: row_q is the row read at the previous clock for this port's address.
module ram_tile_lane
    import ram_tile_pkg::*;
#(
    parameter int  WIDTH     = 72,
    parameter bit  SPLIT_PAR = 1'b0,
    localparam int BWE_W     = bwe_width(WIDTH, SPLIT_PAR),
    localparam int SHIFT     = sub_shift(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOW_W-1:0]  low_addr,
    input  logic              hit,
    input  logic              we,
    input  logic [WIDTH-1:0]  din,
    input  logic [BWE_W-1:0]  bwe,
    input  logic [ROW_W-1:0]  row_q,
    output logic [ROW_AW-1:0] row_idx,
    output logic [ROW_W-1:0]  wdata,
    output logic [ROW_W-1:0]  wbits,
    output logic [WIDTH-1:0]  dout
);

    logic [SUB_W-1:0] slice;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] off_q;
    logic             hit_q;
    logic [WIDTH-1:0] lane_en;

    // Expand the lane enables to one enable per data bit.
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam int GRP = bwe_group(WIDTH, SPLIT_PAR, i);
            assign lane_en[i] = bwe[GRP];
        end
    endgenerate

    // Split the low address into a row and a bit offset inside the row.
    always_comb begin
        row_idx = low_addr[LOW_W-1:SUB_W];
        slice   = low_addr[SUB_W-1:0] >> SHIFT;
        off     = OFF_W'(slice) * OFF_W'(WIDTH);
    end

    // Place write data and the gated mask at the slice position.
    always_comb begin
        wdata = ROW_W'(din) << off;
        wbits = (we && hit) ? (ROW_W'(lane_en) << off) : '0;
    end

    // Remember where the read word sits and whether it was ours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            off_q <= '0;
        end else begin
            hit_q <= hit;
            off_q <= off;
        end
    end

    // Extract the word, or drive zero for a foreign access.
    always_comb dout = hit_q ? WIDTH'(row_q >> off_q) : '0;

endmodule

// File: rtl/ram_tile.sv
// Cascadable two-port RAM tile, top level.
// A 4096 x 72 store shared by ports A and B. Each port has a width adapter and
// a self-select comparator. Reads are registered (one cycle) and read-first.
// When both ports write one row in a cycle, B's enabled bits land last.
// Assumes: WIDTH is 72, 36, 18 or 9; SPLIT_PAR matters only at 72.
module ram_tile
    import ram_tile_pkg::*;
#(
    parameter int              WIDTH      = 72,
    parameter bit              SPLIT_PAR  = 1'b0,
    parameter bit              CASCADE_EN = 1'b0,
    parameter logic [UP_W-1:0] SELF_ID    = '0,
    parameter logic [UP_W-1:0] SELF_MASK  = '1,
    localparam int             BWE_W      = bwe_width(WIDTH, SPLIT_PAR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WIDTH-1:0]  a_din,
    input  logic              a_we,
    input  logic [BWE_W-1:0]  a_bwe,
    output logic [WIDTH-1:0]  a_dout,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WIDTH-1:0]  b_din,
    input  logic              b_we,
    input  logic [BWE_W-1:0]  b_bwe,
    output logic [WIDTH-1:0]  b_dout
);

    logic [ROW_W-1:0]  mem [ROWS];
    logic              hit_a, hit_b;
    logic [ROW_AW-1:0] row_a, row_b;
    logic [ROW_W-1:0]  wd_a, wd_b, wm_a, wm_b;
    logic [ROW_W-1:0]  rq_a, rq_b;
    logic [ROW_W-1:0]  nxt_a, nxt_b;

    ram_tile_select #(.CASCADE_EN(CASCADE_EN), .SELF_ID(SELF_ID), .SELF_MASK(SELF_MASK))
    u_sel_a (.upper(a_addr[ADDR_W-1:LOW_W]), .hit(hit_a));

    ram_tile_select #(.CASCADE_EN(CASCADE_EN), .SELF_ID(SELF_ID), .SELF_MASK(SELF_MASK))
    u_sel_b (.upper(b_addr[ADDR_W-1:LOW_W]), .hit(hit_b));

    ram_tile_lane #(.WIDTH(WIDTH), .SPLIT_PAR(SPLIT_PAR)) u_lane_a (
        .clk(clk), .rst_n(rst_n), .low_addr(a_addr[LOW_W-1:0]), .hit(hit_a),
        .we(a_we), .din(a_din), .bwe(a_bwe), .row_q(rq_a),
        .row_idx(row_a), .wdata(wd_a), .wbits(wm_a), .dout(a_dout)
    );

    ram_tile_lane #(.WIDTH(WIDTH), .SPLIT_PAR(SPLIT_PAR)) u_lane_b (
        .clk(clk), .rst_n(rst_n), .low_addr(b_addr[LOW_W-1:0]), .hit(hit_b),
        .we(b_we), .din(b_din), .bwe(b_bwe), .row_q(rq_b),
        .row_idx(row_b), .wdata(wd_b), .wbits(wm_b), .dout(b_dout)
    );

    // Merge each port's masked data into the row; B builds on A when rows match.
    always_comb begin
        nxt_a = (mem[row_a] & ~wm_a) | (wd_a & wm_a);
        nxt_b = (((row_a == row_b) ? nxt_a : mem[row_b]) & ~wm_b) | (wd_b & wm_b);
    end

    // Store updates, held off during reset.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (wm_a != '0) mem[row_a] <= nxt_a;
            if (wm_b != '0) mem[row_b] <= nxt_b;
        end
    end

    // Read-first row registers, one per port.
    always_ff @(posedge clk) begin
        rq_a <= mem[row_a];
        rq_b <= mem[row_b];
    end

    // R7: a foreign access produces no write mask.
    p_foreign_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_a |-> wm_a == '0) and (!hit_b |-> wm_b == '0));

    // R7: a foreign address at the port reads back as zero next cycle.
    p_foreign_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (CASCADE_EN && (((a_addr[ADDR_W-1:LOW_W] ^ SELF_ID) & SELF_MASK) != '0))
        |=> a_dout == '0);

    // R4: with chaining off, an enabled write always reaches the store.
    p_single_owns_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!CASCADE_EN && a_we && (a_bwe != '0)) |-> wm_a != '0);

    // R8: steady address with no write in between gives steady read data.
    p_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(a_we) && !$past(b_we) && $stable(a_addr))
        |=> $stable(a_dout));

    p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(a_we) && !$past(b_we) && $stable(b_addr))
        |=> $stable(b_dout));

    // R10: reset clears the read outputs.
    p_reset_zero_r10: assert property (@(posedge clk)
        !rst_n |=> (a_dout == '0 && b_dout == '0));

endmodule

// File: tb/ram_tile_bench.sv
// Bench: two tiles (18-bit chained, 72-bit split parity single) against a
// behavioural row model, compared on every clock.
module ram_tile_bench;

    localparam int CLK_P = 10;
    localparam logic [10:0] N_ID   = 11'h2A5;
    localparam logic [10:0] N_MASK = 11'h7F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic [25:0] na_addr = '0, nb_addr = '0, wa_addr = '0, wb_addr = '0;
    logic [71:0] na_din = '0, nb_din = '0, wa_din = '0, wb_din = '0;
    logic        na_we = 1'b0, nb_we = 1'b0, wa_we = 1'b0, wb_we = 1'b0;
    logic [8:0]  na_bwe = '0, nb_bwe = '0, wa_bwe = '0, wb_bwe = '0;
    logic [17:0] na_dout, nb_dout;
    logic [71:0] wa_dout, wb_dout;

    int total = 0;
    int bad = 0;

    logic [71:0] mdl [int];
    logic [71:0] kn  [int];

    ram_tile #(.WIDTH(18), .SPLIT_PAR(1'b0), .CASCADE_EN(1'b1),
               .SELF_ID(N_ID), .SELF_MASK(N_MASK)) u_ram_tile (
        .clk(clk), .rst_n(rst_n),
        .a_addr(na_addr), .a_din(na_din[17:0]), .a_we(na_we), .a_bwe(na_bwe[1:0]), .a_dout(na_dout),
        .b_addr(nb_addr), .b_din(nb_din[17:0]), .b_we(nb_we), .b_bwe(nb_bwe[1:0]), .b_dout(nb_dout)
    );

    ram_tile #(.WIDTH(72), .SPLIT_PAR(1'b1), .CASCADE_EN(1'b0),
               .SELF_ID(11'h001), .SELF_MASK(11'h7FF)) u_ram_tile_wide (
        .clk(clk), .rst_n(rst_n),
        .a_addr(wa_addr), .a_din(wa_din), .a_we(wa_we), .a_bwe(wa_bwe), .a_dout(wa_dout),
        .b_addr(wb_addr), .b_din(wb_din), .b_we(wb_we), .b_bwe(wb_bwe), .b_dout(wb_dout)
    );

    function automatic int sh_m(input int w);
        return (w == 72) ? 3 : (w == 36) ? 2 : (w == 18) ? 1 : 0;
    endfunction

    function automatic int grp_m(input int w, input bit sp, input int i);
        if (w == 72 && sp) return (i < 64) ? i / 8 : 8;
        return i / 9;
    endfunction

    function automatic bit sel_m(input bit casc, input logic [10:0] id,
                                 input logic [10:0] msk, input logic [25:0] a);
        if (!casc) return 1'b1;
        return ((a[25:15] ^ id) & msk) == 11'h0;
    endfunction

    // Expected read value and known-bit mask, from the model before this cycle's writes.
    task automatic predict(input int inst, input int w, input bit casc,
                           input logic [10:0] id, input logic [10:0] msk,
                           input logic [25:0] a,
                           output logic [71:0] ev, output logic [71:0] ek);
        int key = inst * 4096 + int'(a[14:3]);
        int off = int'(a[2:0] >> sh_m(w)) * w;
        logic [71:0] wm = (w == 72) ? '1 : ((72'(1) << w) - 72'(1));
        logic [71:0] v = mdl.exists(key) ? mdl[key] : '0;
        logic [71:0] k = kn.exists(key) ? kn[key] : '0;
        if (!rst_n || !sel_m(casc, id, msk, a)) begin
            ev = '0;
            ek = '1;
        end else begin
            ev = (v >> off) & wm;
            ek = ((k >> off) & wm) | ~wm;
        end
    endtask

    // Apply one port's write to the model.
    task automatic commit(input int inst, input int w, input bit sp, input bit casc,
                          input logic [10:0] id, input logic [10:0] msk,
                          input logic [25:0] a, input logic we,
                          input logic [71:0] din, input logic [8:0] bwe);
        int key = inst * 4096 + int'(a[14:3]);
        int off = int'(a[2:0] >> sh_m(w)) * w;
        logic [71:0] v = mdl.exists(key) ? mdl[key] : '0;
        logic [71:0] k = kn.exists(key) ? kn[key] : '0;
        if (!rst_n || !we || !sel_m(casc, id, msk, a)) return;
        for (int i = 0; i < w; i++) begin
            if (bwe[grp_m(w, sp, i)]) begin
                v[off + i] = din[i];
                k[off + i] = 1'b1;
            end
        end
        mdl[key] = v;
        kn[key]  = k;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [71:0] got, input logic [71:0] ev, input logic [71:0] ek);
        total++;
        if (((got ^ ev) & ek) != '0) begin
            bad++;
            $display("FAIL %s %s: got=%h expected=%h (known mask %h) at %0t",
                     tag, what, got, ev, ek, $time);
        end
    endtask

    // One clock: predict, update the model A then B, then compare after the edge.
    task automatic tick(input string tag);
        logic [71:0] e0, k0, e1, k1, e2, k2, e3, k3;
        predict(0, 18, 1'b1, N_ID, N_MASK, na_addr, e0, k0);
        predict(0, 18, 1'b1, N_ID, N_MASK, nb_addr, e1, k1);
        predict(1, 72, 1'b0, 11'h001, 11'h7FF, wa_addr, e2, k2);
        predict(1, 72, 1'b0, 11'h001, 11'h7FF, wb_addr, e3, k3);
        commit(0, 18, 1'b0, 1'b1, N_ID, N_MASK, na_addr, na_we, na_din, na_bwe);
        commit(0, 18, 1'b0, 1'b1, N_ID, N_MASK, nb_addr, nb_we, nb_din, nb_bwe);
        commit(1, 72, 1'b1, 1'b0, 11'h001, 11'h7FF, wa_addr, wa_we, wa_din, wa_bwe);
        commit(1, 72, 1'b1, 1'b0, 11'h001, 11'h7FF, wb_addr, wb_we, wb_din, wb_bwe);
        @(posedge clk);
        #(CLK_P/4);
        check(tag, "narrow A", 72'(na_dout), e0, k0);
        check(tag, "narrow B", 72'(nb_dout), e1, k1);
        check(tag, "wide A", wa_dout, e2, k2);
        check(tag, "wide B", wb_dout, e3, k3);
    endtask

    task automatic quiet();
        na_we = 1'b0; nb_we = 1'b0; wa_we = 1'b0; wb_we = 1'b0;
    endtask

    function automatic logic [25:0] nad(input logic [10:0] up, input logic [14:0] lo);
        return {up, lo};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P/4);
        // R10: outputs held at zero during reset.
        for (int i = 0; i < 3; i++) tick("R10");
        rst_n = 1'b1;

        // R1: fill four slices of one row plus the top word through port A.
        for (int s = 0; s < 4; s++) begin
            na_addr = nad(N_ID, 15'(8 + 2 * s)); na_we = 1'b1;
            na_din = 72'(18'h1000 + s * 18'h0111); na_bwe = 9'h003;
            tick("R1");
        end
        na_addr = nad(N_ID, 15'h7FFE); na_din = 72'(18'h2ABCD); tick("R1");
        quiet();
        for (int s = 0; s < 4; s++) begin
            nb_addr = nad(N_ID, 15'(8 + 2 * s)); tick("R1");
        end
        nb_addr = nad(N_ID, 15'h7FFE); tick("R1");
        nb_addr = nad(N_ID, 15'h7FFF); tick("R2");
        nb_addr = nad(N_ID, 15'h0009); tick("R2");
        nb_addr = nad(N_ID, 15'h000B); tick("R2");

        // R3: masked-out upper bits still match; a compared bit does not.
        nb_addr = nad(N_ID ^ 11'h00F, 15'h000A); tick("R3");
        nb_addr = nad(N_ID ^ 11'h010, 15'h000A); tick("R3");
        nb_addr = nad(N_ID ^ 11'h400, 15'h000A); tick("R3");

        // R7: foreign write leaves the word alone.
        na_addr = nad(N_ID ^ 11'h020, 15'h0008); na_we = 1'b1;
        na_din = 72'(18'h3FFFF); na_bwe = 9'h003; tick("R7");
        quiet(); na_addr = nad(N_ID, 15'h0008); tick("R7");
        tick("R7");

        // R5: only the low 9-bit lane written.
        na_we = 1'b1; na_din = 72'(18'h3FFFF); na_bwe = 9'h001; tick("R5");
        quiet(); tick("R5");
        na_we = 1'b1; na_din = 72'(18'h00000); na_bwe = 9'h002; tick("R5");
        quiet(); tick("R5");

        // R8: A writes while B reads the same word; A also reads its own write.
        na_addr = nad(N_ID, 15'h000A); nb_addr = nad(N_ID, 15'h000A);
        na_we = 1'b1; na_din = 72'(18'h15A5A); na_bwe = 9'h003; tick("R8");
        quiet(); tick("R8");

        // R9: both ports write one word, full overlap then disjoint lanes.
        na_addr = nad(N_ID, 15'h000C); nb_addr = nad(N_ID, 15'h000C);
        na_we = 1'b1; nb_we = 1'b1;
        na_din = 72'(18'h11111); nb_din = 72'(18'h22222);
        na_bwe = 9'h003; nb_bwe = 9'h003; tick("R9");
        na_bwe = 9'h001; nb_bwe = 9'h002;
        na_din = 72'(18'h3C0F0); nb_din = 72'(18'h0F3C3); tick("R9");
        quiet(); tick("R9");
        tick("R9");

        // R4: single tile ignores upper bits.
        wa_addr = {11'h7AB, 15'h0040}; wa_we = 1'b1;
        wa_din = 72'h8F_1122_3344_5566_7788; wa_bwe = 9'h1FF; tick("R4");
        quiet(); wb_addr = {11'h003, 15'h0040}; tick("R4");
        wb_addr = {11'h000, 15'h0047}; tick("R2");

        // R6: parity lane and first data byte written separately.
        wa_addr = {11'h155, 15'h0040}; wa_we = 1'b1;
        wa_din = 72'h3C_FFFF_FFFF_FFFF_FFFF; wa_bwe = 9'h100; tick("R6");
        wa_din = 72'h00_0000_0000_0000_00A5; wa_bwe = 9'h001; tick("R6");
        wa_din = 72'hFF_0000_0000_0000_FF00; wa_bwe = 9'h002; tick("R6");
        quiet(); tick("R6");
        tick("R6");

        // Mixed traffic with frequent collisions.
        for (int n = 0; n < 600; n++) begin
            logic [10:0] ups [3];
            ups[0] = N_ID; ups[1] = N_ID ^ 11'h00F; ups[2] = N_ID ^ 11'h010;
            na_addr = nad(ups[$urandom % 3], 15'($urandom % 32));
            nb_addr = nad(ups[$urandom % 3], 15'($urandom % 32));
            na_we = 1'($urandom); nb_we = 1'($urandom);
            na_din = {$urandom, $urandom, $urandom}; nb_din = {$urandom, $urandom, $urandom};
            na_bwe = 9'($urandom); nb_bwe = 9'($urandom);
            wa_addr = {11'($urandom), 15'($urandom % 32)};
            wb_addr = {11'($urandom), 15'($urandom % 32)};
            wa_we = 1'($urandom); wb_we = 1'($urandom);
            wa_din = {$urandom, $urandom, $urandom}; wb_din = {$urandom, $urandom, $urandom};
            wa_bwe = 9'($urandom); wb_bwe = 9'($urandom);
            tick("R9");
        end
        quiet();
        tick("R8");

        // R10: reset again clears outputs.
        rst_n = 1'b0;
        tick("R10");
        tick("R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule